// File: doc/BRIEF.md
# System Snoop Hold Arbiter

This block sits on the system side, between an external bus master and a processor with a write-back cache that snoops the bus. When the master opens a cycle with its address strobe, the block passes that strobe straight through, in the same clock, as the processor's snoop strobe. The master's address and invalidate request travel with it. Two clocks later the processor reports whether the snooped line is dirty.

On a clean result the master's cycle simply proceeds. On a dirty result the block does two things in the same clock: it withdraws the hold request from the processor and backs off the master. The processor can then take the bus and write the line back. The block raises the hold request again as soon as it sees the processor's write-back strobe. It then waits for the processor to acknowledge the hold. After the acknowledge it lifts the back-off and marks the retry with a one-clock pulse. The master then replays the aborted access, which starts a second snoop of the same line.

Top module: `snoop_hold_arb`

## Requirements
- R1: While the block is idle, `snp_strobe_n` equals `mst_strobe_n` in the same clock. While the master strobe is low, `snp_addr` and `snp_inval` equal `mst_addr` and `mst_inval`.
- R2: While `snp_strobe_n` is high, `snp_addr` and `snp_inval` hold the address and invalidate value of the most recent accepted strobe.
- R3: `cpu_dirty_hit_n` is sampled on the HIT_DLY-th rising edge after the edge that accepted the strobe (HIT_DLY=2 by default). A high sample returns the block to idle, and `cpu_hold_req` and `mst_backoff_n` stay at 1.
- R4: A low sample drives `cpu_hold_req` to 0 and `mst_backoff_n` to 0 together, in the clock after the sample.
- R5: `cpu_hold_req` stays 0 until `cpu_strobe_n` is sampled low. It is 1 from the next clock on, while `mst_backoff_n` is still 0.
- R6: After R5, `mst_backoff_n` stays 0 until `cpu_hold_ack` is sampled 1. In the next clock `mst_backoff_n` returns to 1 and `retry_pulse` is 1 for exactly that one clock.
- R7: A master strobe arriving while the block is not idle (snoop wait, back-off, hold wait, release) produces no snoop strobe: `snp_strobe_n` stays 1.
- R8: During and right after reset, `cpu_hold_req`=1, `mst_backoff_n`=1, `retry_pulse`=0 and the block is idle.
- R9: After the release, the master's replayed strobe is passed through again with the same address and invalidate value. A clean result on that second snoop leaves the master free to proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mst_strobe_n | input | 1 | External master address strobe, active low |
| mst_addr | input | AW | External master address |
| mst_inval | input | 1 | Master requests invalidation of the snooped line |
| mst_backoff_n | output | 1 | Back-off to the external master, active low |
| snp_strobe_n | output | 1 | Snoop strobe to the processor, active low |
| snp_addr | output | AW | Snoop address to the processor |
| snp_inval | output | 1 | Snoop invalidate to the processor |
| cpu_dirty_hit_n | input | 1 | Processor reports a hit on a modified line, active low |
| cpu_strobe_n | input | 1 | Processor address strobe (write-back start), active low |
| cpu_hold_req | output | 1 | Hold request to the processor, active high |
| cpu_hold_ack | input | 1 | Hold acknowledge from the processor |
| retry_pulse | output | 1 | One-clock mark of each release for retry |

## Verification
The hardest situation to reach is the full dirty-hit round trip. It needs a strobe, then a low hit report placed on exactly the sampling edge, then a processor write-back strobe, then a fresh hold acknowledge, and finally a replayed master strobe. That last step exercises the second snoop. The bench plays the processor inline inside one task. It drives each of these inputs at a falling edge, counted from the accepting edge. It holds back the write-back strobe and the acknowledge for several clocks so that the waiting states are observed. During back-off and hold wait it fires extra master strobes to show that they are blocked.

// File: rtl/snoop_hold_arb.sv
module snoop_hold_arb #(
  parameter int AW      = 32,
  parameter int HIT_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mst_strobe_n,
  input  logic [AW-1:0] mst_addr,
  input  logic          mst_inval,
  output logic          mst_backoff_n,
  output logic          snp_strobe_n,
  output logic [AW-1:0] snp_addr,
  output logic          snp_inval,
  input  logic          cpu_dirty_hit_n,
  input  logic          cpu_strobe_n,
  output logic          cpu_hold_req,
  input  logic          cpu_hold_ack,
  output logic          retry_pulse
);

  localparam int CW = (HIT_DLY > 1) ? $clog2(HIT_DLY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HIT_DLY - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SNOOP_WAIT, ST_BACKOFF, ST_WAIT_ACK, ST_RELEASE
  } arb_state_t;

  arb_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic          inval_q;
  logic          take;

  assign take          = (state_q == ST_IDLE) && !mst_strobe_n;
  assign snp_strobe_n  = !take;
  assign snp_addr      = take ? mst_addr  : addr_q;
  assign snp_inval     = take ? mst_inval : inval_q;
  assign cpu_hold_req  = (state_q != ST_BACKOFF);
  assign mst_backoff_n = !((state_q == ST_BACKOFF) || (state_q == ST_WAIT_ACK));
  assign retry_pulse   = (state_q == ST_RELEASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      inval_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_SNOOP_WAIT;
          cnt_q   <= '0;
          addr_q  <= mst_addr;
          inval_q <= mst_inval;
        end
        ST_SNOOP_WAIT: begin
          if (cnt_q == CNT_LAST)
            state_q <= cpu_dirty_hit_n ? ST_IDLE : ST_BACKOFF;
          else
            cnt_q <= cnt_q + 1'b1;
        end
        ST_BACKOFF:  if (!cpu_strobe_n) state_q <= ST_WAIT_ACK;
        ST_WAIT_ACK: if (cpu_hold_ack)  state_q <= ST_RELEASE;
        ST_RELEASE:  state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/snoop_hold_arb_chk.sv
module snoop_hold_arb_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mst_strobe_n,
  input logic          mst_backoff_n,
  input logic          snp_strobe_n,
  input logic          cpu_strobe_n,
  input logic          cpu_hold_req,
  input logic          cpu_hold_ack,
  input logic          retry_pulse
);

  // R1
  snoop_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_strobe_n |-> !mst_strobe_n);

  // R7
  no_snoop_in_backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_backoff_n |-> snp_strobe_n);

  // R4
  hold_drop_with_backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold_req) |-> !mst_backoff_n);

  // R5
  hold_return_on_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_hold_req) |-> ($past(cpu_strobe_n) == 1'b0) && !mst_backoff_n);

  // R6
  release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_backoff_n) |-> retry_pulse && $past(cpu_hold_ack));

  // R6
  retry_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |=> !retry_pulse);

endmodule

bind snoop_hold_arb snoop_hold_arb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mst_strobe_n(mst_strobe_n),
  .mst_backoff_n(mst_backoff_n), .snp_strobe_n(snp_strobe_n),
  .cpu_strobe_n(cpu_strobe_n), .cpu_hold_req(cpu_hold_req),
  .cpu_hold_ack(cpu_hold_ack), .retry_pulse(retry_pulse)
);

// File: tb/snoop_hold_arb_bench.sv
module snoop_hold_arb_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mst_strobe_n = 1'b1;
  logic [AW-1:0] mst_addr = '0;
  logic mst_inval = 1'b0;
  logic cpu_dirty_hit_n = 1'b1;
  logic cpu_strobe_n = 1'b1;
  logic cpu_hold_ack = 1'b1;
  logic mst_backoff_n, snp_strobe_n, snp_inval, cpu_hold_req, retry_pulse;
  logic [AW-1:0] snp_addr;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  snoop_hold_arb #(.AW(AW), .HIT_DLY(2)) u_snoop_hold_arb (
    .clk(clk), .rst_n(rst_n), .mst_strobe_n(mst_strobe_n), .mst_addr(mst_addr),
    .mst_inval(mst_inval), .mst_backoff_n(mst_backoff_n), .snp_strobe_n(snp_strobe_n),
    .snp_addr(snp_addr), .snp_inval(snp_inval), .cpu_dirty_hit_n(cpu_dirty_hit_n),
    .cpu_strobe_n(cpu_strobe_n), .cpu_hold_req(cpu_hold_req),
    .cpu_hold_ack(cpu_hold_ack), .retry_pulse(retry_pulse)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    #1;
    chk("R8 hold", cpu_hold_req, 1);
    chk("R8 backoff", mst_backoff_n, 1);
    chk("R8 retry", retry_pulse, 0);
    chk("R8 snoop", snp_strobe_n, 1);
    rst_n = 1'b1;
    step(); #1;
    chk("R8 hold after", cpu_hold_req, 1);
  endtask

  // drive a master strobe for one clock; returns after the accepting edge's falling edge
  task automatic strobe(input logic [AW-1:0] a, input logic inv);
    mst_strobe_n = 1'b0; mst_addr = a; mst_inval = inv;
    #1;
    chk("R1 strobe pass", snp_strobe_n, 0);
    chk("R1 addr pass", snp_addr, a);
    chk("R1 inval pass", snp_inval, inv);
    step();
    mst_strobe_n = 1'b1;
  endtask

  task automatic t_clean();
    strobe(32'hA000_1230, 1'b1);
    mst_addr = 32'h5555_0000; mst_inval = 1'b0;
    #1;
    chk("R2 addr held", snp_addr, 32'hA000_1230);
    chk("R2 inval held", snp_inval, 1);
    mst_strobe_n = 1'b0;
    #1;
    chk("R7 strobe in snoop wait", snp_strobe_n, 1);
    step();
    mst_strobe_n = 1'b1;
    cpu_dirty_hit_n = 1'b1;
    step(); #1;
    chk("R3 clean hold", cpu_hold_req, 1);
    chk("R3 clean backoff", mst_backoff_n, 1);
    cpu_dirty_hit_n = 1'b0;
    step(); #1;
    chk("R3 late low ignored", mst_backoff_n, 1);
    cpu_dirty_hit_n = 1'b1;
    strobe(32'h0000_0044, 1'b0);
    step(); step(); #1;
    chk("R3 idle after clean", cpu_hold_req, 1);
  endtask

  task automatic t_dirty();
    strobe(32'hDEAD_BEE0, 1'b1);
    step();
    cpu_dirty_hit_n = 1'b0;
    #1;
    chk("R3 not yet", mst_backoff_n, 1);
    step(); #1;
    cpu_dirty_hit_n = 1'b1;
    chk("R4 hold drop", cpu_hold_req, 0);
    chk("R4 backoff", mst_backoff_n, 0);
    cpu_hold_ack = 1'b0;
    mst_strobe_n = 1'b0; mst_addr = 32'h1111_1111;
    #1;
    chk("R7 strobe in backoff", snp_strobe_n, 1);
    step();
    mst_strobe_n = 1'b1;
    step(); step(); #1;
    chk("R5 hold stays low", cpu_hold_req, 0);
    cpu_strobe_n = 1'b0;
    step(); #1;
    cpu_strobe_n = 1'b1;
    chk("R5 hold back", cpu_hold_req, 1);
    chk("R5 backoff kept", mst_backoff_n, 0);
    mst_strobe_n = 1'b0;
    #1;
    chk("R7 strobe in hold wait", snp_strobe_n, 1);
    step();
    mst_strobe_n = 1'b1;
    step(); #1;
    chk("R6 backoff until ack", mst_backoff_n, 0);
    chk("R6 no early retry", retry_pulse, 0);
    cpu_hold_ack = 1'b1;
    step(); #1;
    chk("R6 release", mst_backoff_n, 1);
    chk("R6 retry pulse", retry_pulse, 1);
    mst_strobe_n = 1'b0;
    #1;
    chk("R7 strobe in release", snp_strobe_n, 1);
    mst_strobe_n = 1'b1;
    step(); #1;
    chk("R6 pulse one clock", retry_pulse, 0);
    strobe(32'hDEAD_BEE0, 1'b1);
    chk("R9 retry addr", snp_addr, 32'hDEAD_BEE0);
    step(); step(); step(); #1;
    chk("R9 no second backoff", mst_backoff_n, 1);
    chk("R9 hold kept", cpu_hold_req, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_clean();
        t_dirty();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule